// File: doc/BRIEF.md
# Data Address Breakpoint Match Unit

This block sits beside a processor's load/store path and decides, for every data access, whether a debug breakpoint should fire. It holds two address registers and one control register. The second address register can serve as a separate breakpoint, or as a bit mask that widens the first breakpoint to cover a range of addresses. Each access presents an address, a size, an access-type code and a valid strobe. A hit produces a one-cycle pulse, a method-of-entry code and a link value. The access itself always proceeds, and the block never aborts it.

The same block also handles the software breakpoint instruction. When the decoder reports that instruction, it raises a debug event only while the global debug-enable input is high. When that input is low, the instruction does nothing. Exception vectoring and the debug handler are outside this block.

Top module: `dbp_match_top`

## Requirements
- R1: After reset deasserts, `hit_o` and `swbk_o` are 0, `moe_o` is 3'b000, and all three registers read as zero. With zero registers no access can hit.
- R2: Each enable field uses this encoding:
  - 2'b00: disabled.
  - 2'b01: fires on store-class accesses only.
  - 2'b10: fires on any triggering access.
  - 2'b11: fires on loads only.
  The access-type codes are 0 load, 1 store, 2 swap, 3 preload hint and 4 cache/TLB maintenance. A swap (code 2) belongs to the store class.
- R3: Preload (code 3) and maintenance (code 4) accesses never hit, whatever the register settings.
- R4: An access hits when any byte it covers equals the breakpoint address. The size codes are 0 = 1 byte, 1 = 2 bytes and 2 or 3 = 4 bytes. An aligned access covers the bytes from its address upward.
- R5: An access whose address is not a multiple of its size is handled as if it started at its address rounded down to a multiple of 4.
- R6: Mask mode is set by control bit 4.
  - Every bit set in the second register is ignored when the access bytes are compared with the first register.
  - The second enable field has no effect in this mode.
  - Nothing hits while the first enable field is 2'b00.
- R7: When control bit 4 is 0, the second register is an independent breakpoint. Its own enable field (control bits [3:2]) gates it.
- R8: A hit is reported on the clock edge after the accepted access, as follows:
  - `hit_o` is high for exactly one cycle.
  - `moe_o` is 3'b010 in that cycle.
  - `link_o` holds the `next_pc_i` value sampled with the access, plus 4.
- R9: When `swbk_i` is high and `dbg_en_i` is high, `swbk_o` pulses on the next edge and `link_o` takes `next_pc_i` + 4.
  - If no data hit occurs in the same cycle, `moe_o` is 3'b011.
  - If a data hit occurs in the same cycle, `moe_o` is 3'b010.
  - When `dbg_en_i` is low, the instruction has no effect.
- R10: When `reg_we_i` is high, the write takes effect on the next edge. Select 0 writes the first address, 1 writes the second address or mask, and 2 writes the control register. In the control register, bits [1:0] are the first enable, [3:2] are the second enable and [4] is mask mode. Select 3 is ignored.
- R11: In any cycle without a debug event, `moe_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 first address, 1 second address/mask, 2 control |
| reg_wdata_i | input | AW | Register write data |
| acc_valid_i | input | 1 | Data access valid |
| acc_addr_i | input | AW | Data access byte address |
| acc_size_i | input | 2 | Access size code |
| acc_type_i | input | 3 | Access type code |
| next_pc_i | input | AW | Address of the next instruction |
| swbk_i | input | 1 | Software breakpoint instruction executed |
| dbg_en_i | input | 1 | Global debug enable |
| hit_o | output | 1 | Data breakpoint pulse |
| swbk_o | output | 1 | Software breakpoint debug event pulse |
| moe_o | output | 3 | Method-of-entry code |
| link_o | output | AW | Link value (next PC + 4) |

## Verification
On every cycle, the assertions check the timing and the shape of each event:
- A hit or software event only ever follows a valid request from the cycle before.
- The entry code and the link value agree with that event.
- Preload and maintenance accesses never produce a hit.
- A software breakpoint with debug disabled produces nothing.

Whether an access should have hit is a different matter, and only the bench's sweeps can show it. Those sweeps cover byte-lane coverage, the rounding of unaligned addresses, range matching in mask mode and the per-type enable codes. The bench compares every access against a byte-by-byte model across many register setups.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned OFFW  = $clog2(LANES);

  localparam logic [2:0] ACC_LOAD    = 3'd0;
  localparam logic [2:0] ACC_STORE   = 3'd1;
  localparam logic [2:0] ACC_SWAP    = 3'd2;
  localparam logic [2:0] ACC_PRELOAD = 3'd3;
  localparam logic [2:0] ACC_CMAINT  = 3'd4;

  localparam logic [1:0] EN_OFF   = 2'b00;
  localparam logic [1:0] EN_STORE = 2'b01;
  localparam logic [1:0] EN_ANY   = 2'b10;
  localparam logic [1:0] EN_LOAD  = 2'b11;

  localparam logic [2:0] MOE_NONE = 3'b000;
  localparam logic [2:0] MOE_DATA = 3'b010;
  localparam logic [2:0] MOE_SWBK = 3'b011;

  localparam logic [1:0] SEL_BP0  = 2'd0;
  localparam logic [1:0] SEL_BP1  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef struct packed {
    logic       mask_mode;
    logic [1:0] en1;
    logic [1:0] en0;
  } dbp_ctrl_t;
endpackage

// File: rtl/dbp_regs.sv
module dbp_regs
  import dbp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] bp0_o,
  output logic [AW-1:0] bp1_o,
  output dbp_ctrl_t     ctrl_o
);
  localparam int unsigned CW = $bits(dbp_ctrl_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp0_o  <= '0;
      bp1_o  <= '0;
      ctrl_o <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_BP0:  bp0_o  <= wdata_i;
        SEL_BP1:  bp1_o  <= wdata_i;
        SEL_CTRL: ctrl_o <= dbp_ctrl_t'(wdata_i[CW-1:0]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/dbp_lane_gen.sv
module dbp_lane_gen
  import dbp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]      addr_i,
  input  logic [1:0]         size_i,
  output logic [AW-OFFW-1:0] word_o,
  output logic [LANES-1:0]   lanes_o
);
  logic [OFFW:0]   nbytes;
  logic [OFFW-1:0] low_mask;
  logic [OFFW-1:0] off;
  logic [OFFW-1:0] start;
  logic            unal;

  assign word_o = addr_i[AW-1:OFFW];
  assign off    = addr_i[OFFW-1:0];

  always_comb begin
    unique case (size_i)
      2'd0:    begin nbytes = 3'd1; low_mask = 2'b00; end
      2'd1:    begin nbytes = 3'd2; low_mask = 2'b01; end
      default: begin nbytes = 3'd4; low_mask = 2'b11; end
    endcase
    unal  = |(off & low_mask);
    // unaligned: round down to word base
    start = unal ? '0 : off;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFFW:0] LIDX = (OFFW+1)'(l);
    assign lanes_o[l] = (LIDX >= {1'b0, start}) && (LIDX < ({1'b0, start} + nbytes));
  end
endmodule

// File: rtl/dbp_addr_cmp.sv
module dbp_addr_cmp
  import dbp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-OFFW-1:0] word_i,
  input  logic [LANES-1:0]   lanes_i,
  input  logic [AW-1:0]      bp_i,
  input  logic [AW-1:0]      ign_i,
  output logic               match_o
);
  logic             word_hit;
  logic [LANES-1:0] lane_hit;

  assign word_hit = ((word_i ^ bp_i[AW-1:OFFW]) & ~ign_i[AW-1:OFFW]) == '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFFW-1:0] LIDX = OFFW'(l);
    assign lane_hit[l] = lanes_i[l] &&
                         (((LIDX ^ bp_i[OFFW-1:0]) & ~ign_i[OFFW-1:0]) == '0);
  end

  assign match_o = word_hit && (|lane_hit);
endmodule

// File: rtl/dbp_type_gate.sv
module dbp_type_gate
  import dbp_pkg::*;
(
  input  logic [1:0] en_i,
  input  logic [2:0] type_i,
  output logic       allow_o
);
  logic is_load, is_store;

  assign is_load  = (type_i == ACC_LOAD);
  assign is_store = (type_i == ACC_STORE) || (type_i == ACC_SWAP);

  always_comb begin
    unique case (en_i)
      EN_STORE: allow_o = is_store;
      EN_ANY:   allow_o = is_store || is_load;
      EN_LOAD:  allow_o = is_load;
      default:  allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbp_match_top.sv
module dbp_match_top
  import dbp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_size_i,
  input  logic [2:0]    acc_type_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          swbk_i,
  input  logic          dbg_en_i,
  output logic          hit_o,
  output logic          swbk_o,
  output logic [2:0]    moe_o,
  output logic [AW-1:0] link_o
);
  localparam int unsigned NBP = 2;

  logic [AW-1:0]      bp0, bp1;
  dbp_ctrl_t          ctrl;
  logic [AW-OFFW-1:0] acc_word;
  logic [LANES-1:0]   acc_lanes;

  logic [AW-1:0] bp_addr [NBP];
  logic [AW-1:0] bp_ign  [NBP];
  logic [1:0]    bp_en   [NBP];
  logic [NBP-1:0] bp_live, bp_match, bp_allow;

  logic data_hit, sw_evt;

  dbp_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .bp0_o   (bp0),
    .bp1_o   (bp1),
    .ctrl_o  (ctrl)
  );

  dbp_lane_gen #(.AW(AW)) u_lanes (
    .addr_i  (acc_addr_i),
    .size_i  (acc_size_i),
    .word_o  (acc_word),
    .lanes_o (acc_lanes)
  );

  // slot 0: first bp, masked by bp1 in mask mode; slot 1: independent bp1
  assign bp_addr[0] = bp0;
  assign bp_ign[0]  = ctrl.mask_mode ? bp1 : '0;
  assign bp_en[0]   = ctrl.en0;
  assign bp_live[0] = 1'b1;
  assign bp_addr[1] = bp1;
  assign bp_ign[1]  = '0;
  assign bp_en[1]   = ctrl.en1;
  assign bp_live[1] = !ctrl.mask_mode;

  for (genvar i = 0; i < NBP; i++) begin : g_bp
    dbp_addr_cmp #(.AW(AW)) u_cmp (
      .word_i  (acc_word),
      .lanes_i (acc_lanes),
      .bp_i    (bp_addr[i]),
      .ign_i   (bp_ign[i]),
      .match_o (bp_match[i])
    );
    dbp_type_gate u_gate (
      .en_i    (bp_en[i]),
      .type_i  (acc_type_i),
      .allow_o (bp_allow[i])
    );
  end

  assign data_hit = acc_valid_i && (|(bp_live & bp_match & bp_allow));
  assign sw_evt   = swbk_i && dbg_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      swbk_o <= 1'b0;
      moe_o  <= MOE_NONE;
      link_o <= '0;
    end else begin
      hit_o  <= data_hit;
      swbk_o <= sw_evt;
      moe_o  <= data_hit ? MOE_DATA : (sw_evt ? MOE_SWBK : MOE_NONE);
      if (data_hit || sw_evt) link_o <= next_pc_i + AW'(4);
    end
  end
endmodule

// File: rtl/dbp_match_chk.sv
module dbp_match_chk
  import dbp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic [2:0]    acc_type_i,
  input logic [AW-1:0] next_pc_i,
  input logic          swbk_i,
  input logic          dbg_en_i,
  input logic          hit_o,
  input logic          swbk_o,
  input logic [2:0]    moe_o,
  input logic [AW-1:0] link_o
);
  // R8
  hit_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(acc_valid_i));

  // R8
  hit_moe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> moe_o == MOE_DATA);

  // R8
  hit_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> link_o == $past(next_pc_i) + AW'(4));

  // R3
  no_preload_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_valid_i) && ($past(acc_type_i) == ACC_PRELOAD ||
                           $past(acc_type_i) == ACC_CMAINT) |-> !hit_o);

  // R9
  swbk_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swbk_o |-> $past(swbk_i) && $past(dbg_en_i));

  // R9
  swbk_moe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swbk_o && !hit_o |-> moe_o == MOE_SWBK);

  // R11
  idle_moe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o && !swbk_o |-> moe_o == MOE_NONE);
endmodule

bind dbp_match_top dbp_match_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_dbp_match_top.sv
module sim_dbp_match_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_sel_i = '0;
  logic [AW-1:0] reg_wdata_i = '0;
  logic          acc_valid_i = 1'b0;
  logic [AW-1:0] acc_addr_i = '0;
  logic [1:0]    acc_size_i = '0;
  logic [2:0]    acc_type_i = '0;
  logic [AW-1:0] next_pc_i = '0;
  logic          swbk_i = 1'b0;
  logic          dbg_en_i = 1'b0;
  logic          hit_o, swbk_o;
  logic [2:0]    moe_o;
  logic [AW-1:0] link_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbp_match_top #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .acc_valid_i(acc_valid_i), .acc_addr_i(acc_addr_i),
    .acc_size_i(acc_size_i), .acc_type_i(acc_type_i), .next_pc_i(next_pc_i),
    .swbk_i(swbk_i), .dbg_en_i(dbg_en_i), .hit_o(hit_o), .swbk_o(swbk_o),
    .moe_o(moe_o), .link_o(link_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  // byte-by-byte reference built from the requirements
  function automatic bit model_hit(input logic [31:0] a, input int sz, input int ty,
                                   input logic [31:0] b0, input logic [31:0] b1,
                                   input logic [4:0] c);
    int n;
    logic [31:0] st, b, keep;
    bit ld, stc, ok0, ok1, m0, m1;
    n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    st  = ((a % n) != 0) ? {a[31:2], 2'b00} : a;
    ld  = (ty == 0);
    stc = (ty == 1) || (ty == 2);
    ok0 = (c[1:0] == 2'b10 && (ld || stc)) || (c[1:0] == 2'b01 && stc) || (c[1:0] == 2'b11 && ld);
    ok1 = (c[3:2] == 2'b10 && (ld || stc)) || (c[3:2] == 2'b01 && stc) || (c[3:2] == 2'b11 && ld);
    keep = c[4] ? ~b1 : 32'hFFFF_FFFF;
    m0 = 1'b0; m1 = 1'b0;
    for (int k = 0; k < n; k++) begin
      b = st + 32'(k);
      if (((b ^ b0) & keep) == 0) m0 = 1'b1;
      if (b == b1) m1 = 1'b1;
    end
    return (ok0 && m0) || (!c[4] && ok1 && m1);
  endfunction

  task automatic access(input logic [31:0] a, input int sz, input int ty,
                        input logic [31:0] pc, input bit exp_hit, input string req);
    @(negedge clk);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_size_i = 2'(sz);
    acc_type_i = 3'(ty); next_pc_i = pc;
    @(negedge clk);
    acc_valid_i = 1'b0;
    check(req, {63'd0, hit_o}, {63'd0, exp_hit});
    if (exp_hit) begin
      check({req, " moe"}, {61'd0, moe_o}, 64'h2);
      check({req, " link"}, {32'd0, link_o}, {32'd0, pc + 32'd4});
    end else begin
      check({req, " R11 moe"}, {61'd0, moe_o}, 64'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] b0, b1;
    logic [4:0]  c;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hit", {63'd0, hit_o}, 64'd0);
    check("R1 swbk", {63'd0, swbk_o}, 64'd0);
    check("R1 moe", {61'd0, moe_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 hit after release", {63'd0, hit_o}, 64'd0);
    // R1: zero registers cannot hit
    access(32'h0, 2, 0, 32'h100, 1'b0, "R1 zero regs");
    // R10: select 3 ignored, control still disabled
    wr(2'd0, 32'h0000_2000);
    wr(2'd3, 32'h0000_0002);
    access(32'h2000, 2, 0, 32'h104, 1'b0, "R10 sel3 ignored");

    for (int cfg = 0; cfg < 8; cfg++) begin
      case (cfg)
        0: begin b0 = 32'h1005; b1 = 32'h0;    c = 5'b0_00_10; tag = "R2 R4 R5 any"; end
        1: begin b0 = 32'h1005; b1 = 32'h0;    c = 5'b0_00_01; tag = "R2 R3 stores"; end
        2: begin b0 = 32'h1006; b1 = 32'h0;    c = 5'b0_00_11; tag = "R2 loads"; end
        3: begin b0 = 32'h1004; b1 = 32'h000C; c = 5'b1_00_10; tag = "R6 mask range"; end
        4: begin b0 = 32'h1004; b1 = 32'h000C; c = 5'b1_11_01; tag = "R6 en1 ignored"; end
        5: begin b0 = 32'h1004; b1 = 32'h000C; c = 5'b1_10_00; tag = "R6 en0 off"; end
        6: begin b0 = 32'h1001; b1 = 32'h100A; c = 5'b0_01_11; tag = "R7 indep both"; end
        default: begin b0 = 32'h1003; b1 = 32'h100F; c = 5'b0_10_00; tag = "R7 bp1 only"; end
      endcase
      wr(2'd0, b0);
      wr(2'd1, b1);
      wr(2'd2, {27'd0, c});
      for (int a = 32'h0FFC; a < 32'h1014; a++)
        for (int sz = 0; sz < 3; sz++)
          for (int ty = 0; ty < 5; ty++)
            access(32'(a), sz, ty, 32'h8000 + 32'(a) * 16 + 32'(sz * 4 + ty),
                   model_hit(32'(a), sz, ty, b0, b1, c), tag);
    end

    // R9 software breakpoint
    wr(2'd2, 32'h0);
    @(negedge clk);
    swbk_i = 1'b1; dbg_en_i = 1'b0; next_pc_i = 32'h4000;
    @(negedge clk);
    swbk_i = 1'b0;
    check("R9 disabled swbk", {63'd0, swbk_o}, 64'd0);
    check("R9 disabled moe", {61'd0, moe_o}, 64'd0);
    swbk_i = 1'b1; dbg_en_i = 1'b1; next_pc_i = 32'h4010;
    @(negedge clk);
    swbk_i = 1'b0;
    check("R9 enabled swbk", {63'd0, swbk_o}, 64'd1);
    check("R9 enabled moe", {61'd0, moe_o}, 64'h3);
    check("R9 link", {32'd0, link_o}, 64'h4014);
    @(negedge clk);
    check("R9 one pulse", {63'd0, swbk_o}, 64'd0);
    // R9 with simultaneous data hit
    wr(2'd0, 32'h3000);
    wr(2'd2, 32'h2);
    @(negedge clk);
    swbk_i = 1'b1; acc_valid_i = 1'b1; acc_addr_i = 32'h3000;
    acc_size_i = 2'd2; acc_type_i = 3'd1; next_pc_i = 32'h5000;
    @(negedge clk);
    swbk_i = 1'b0; acc_valid_i = 1'b0;
    check("R9 both hit", {62'd0, hit_o, swbk_o}, 64'h3);
    check("R9 both moe", {61'd0, moe_o}, 64'h2);
    @(negedge clk);
    check("R8 single pulse", {63'd0, hit_o}, 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule